// File: doc/BRIEF.md
# Write Byte-Lane Enable Register

This block turns a memory write request into the eight byte-lane strobes that the memory array needs. It watches a 9-bit command word together with a valid strobe, the three low address bits and an endianness select. When it sees a write request, it computes which lanes the transfer covers and registers them. It then holds those lanes steady for the memory controller until the controller acknowledges the write.

Block writes and full eight-byte writes enable every lane. Sized writes of one to seven bytes enable a contiguous run of lanes. That run is mirrored end for end when big-endian is selected. Any size and offset pair that no legal request can produce gives all-zero lanes and raises an error flag for the same hold period.

Top module: `wr_lane_enable`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `lane_en` is 8'h00 and `align_err` is 0.
- R2: A write request is `cmd[8]`=0 and `cmd[7:5]`=3'b010 with `cmd[4]`=1 (attribute `cmd[4:3]` 2 or 3), sampled with `cmd_valid` high. Any other command, or any command with `cmd_valid` low, leaves the outputs unchanged in the idle state.
- R3: A write request with `cmd[4:3]`=2 (block form) loads `lane_en`=8'hFF, whatever the address bits and endianness.
- R4: A write request with `cmd[4:3]`=3 (sized form) has byte count n = `cmd[2:0]`+1. Little-endian (`big_end`=0) sets lanes `addr_lo` through `addr_lo`+n-1, where lane i is bit i and strobes data bits 8i+7:8i. So n=8 at offset 0 gives 8'hFF.
- R5: With `big_end`=1, a sized write sets lane 7-k for every byte k that the little-endian rule would set. For example, one byte at offset 1 gives 8'h40, and two bytes at offset 0 give 8'hC0.
- R6: A sized write is illegal if `addr_lo`+n exceeds 8, or if n is 4 or less and (`addr_lo` mod 4)+n exceeds 4. An illegal write loads `lane_en`=8'h00 and `align_err`=1.
- R7: The outputs change one clock after the accepting edge. They then stay stable until `mem_ack`, and any commands that arrive meanwhile are ignored.
- R8: `mem_ack` while holding clears `lane_en` and `align_err` at the next edge. From the cycle after that, a new request is accepted. `mem_ack` in the idle state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd | input | 9 | Command word (type, attribute, size) |
| addr_lo | input | 3 | Byte offset within the doubleword |
| big_end | input | 1 | 1 selects big-endian lane numbering |
| mem_ack | input | 1 | Memory has completed the held write |
| lane_en | output | 8 | Registered byte-lane enables, bit i for data bits 8i+7:8i |
| align_err | output | 1 | Registered flag for an illegal size and offset pair |

## Verification
The block has no parameters, so the bench builds it with its fixed 8-lane, 9-bit-command shape. Every size from one to eight bytes is crossed with every offset and both endiannesses, which reaches all 64 legal and illegal combinations in each byte order. Random traffic during hold windows, acknowledge pulses in the idle state, and malformed command types show that only a genuine write request, accepted while idle, alters the lanes.

// File: rtl/wr_lane_enable.sv
module wr_lane_enable (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [8:0] cmd,
  input  logic [2:0] addr_lo,
  input  logic       big_end,
  input  logic       mem_ack,
  output logic [7:0] lane_en,
  output logic       align_err
);
  localparam int LANES = 8;

  logic             busy;
  logic [LANES-1:0] en_q;
  logic             err_q;
  logic [LANES-1:0] be_m;

  wire       is_wr   = cmd_valid && !cmd[8] && (cmd[7:5] == 3'd2) && cmd[4];
  wire       blk     = !cmd[3];
  wire [3:0] nbytes  = {1'b0, cmd[2:0]} + 4'd1;
  wire [3:0] dw_end  = {1'b0, addr_lo} + nbytes;
  wire [3:0] wd_end  = {2'b0, addr_lo[1:0]} + nbytes;
  wire       bad     = !blk && ((dw_end > 4'd8) || ((nbytes <= 4'd4) && (wd_end > 4'd4)));
  wire [8:0] ones    = (9'd1 << nbytes) - 9'd1;
  wire [LANES-1:0] le_m = ones[LANES-1:0] << addr_lo;

  always_comb
    for (int i = 0; i < LANES; i++) be_m[i] = le_m[LANES-1-i];

  wire [LANES-1:0] nxt = blk ? '1 : (bad ? '0 : (big_end ? be_m : le_m));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      en_q  <= '0;
      err_q <= 1'b0;
    end else if (busy) begin
      if (mem_ack) begin
        busy  <= 1'b0;
        en_q  <= '0;
        err_q <= 1'b0;
      end
    end else if (is_wr) begin
      busy  <= 1'b1;
      en_q  <= nxt;
      err_q <= bad;
    end
  end

  assign lane_en   = en_q;
  assign align_err = err_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (lane_en == 8'h00) && !align_err);

  a_r2_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !is_wr |=> (lane_en == 8'h00) && !align_err);

  a_r6_err_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (lane_en == 8'h00));

  a_r6_word_contain: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en != 8'h00) && ($countones(lane_en) <= 4) |-> (lane_en[7:4] == 4'h0) || (lane_en[3:0] == 4'h0));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ack |=> $stable(lane_en) && $stable(align_err));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_ack |=> (lane_en == 8'h00) && !align_err && !busy);
endmodule

// File: tb/wr_lane_enable_tb.sv
module wr_lane_enable_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [8:0] cmd = '0;
  logic [2:0] addr_lo = '0;
  logic       big_end = 1'b0;
  logic       mem_ack = 1'b0;
  logic [7:0] lane_en;
  logic       align_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wr_lane_enable u_dut (.*);

  function automatic bit is_write(input logic [8:0] c);
    return (c[8] == 1'b0) && (c[7:5] == 3'b010) && (c[4:3] >= 2'd2);
  endfunction

  // Expected lanes and error from the requirement text
  function automatic void model(input logic [8:0] c, input logic [2:0] a, input logic be,
                                output logic [7:0] m, output logic e);
    int n = int'(c[2:0]) + 1;
    int off = int'(a);
    m = 8'h00;
    e = 1'b0;
    if (c[4:3] == 2'd2) begin m = 8'hFF; return; end
    if (off + n > 8 || (n <= 4 && (off % 4) + n > 4)) begin e = 1'b1; return; end
    for (int k = 0; k < 8; k++)
      if (k >= off && k < off + n) begin
        if (be) m[7-k] = 1'b1; else m[k] = 1'b1;
      end
  endfunction

  task automatic check(input string req, input logic [7:0] em, input logic ee);
    checks++;
    if (lane_en !== em || align_err !== ee) begin
      errors++;
      $display("FAIL %s: lane_en=%h align_err=%b expected lane_en=%h align_err=%b",
               req, lane_en, align_err, em, ee);
    end
  endtask

  // Drive one command at negedge, check one cycle later, then hold and ack
  task automatic issue(input logic [8:0] c, input logic [2:0] a, input logic be, input int hold);
    logic [7:0] em; logic ee;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; addr_lo = a; big_end = be;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!is_write(c)) begin
      check("R2", 8'h00, 1'b0);
      return;
    end
    model(c, a, be, em, ee);
    check(c[3] ? (ee ? "R6" : (be ? "R5" : "R4")) : "R3", em, ee);
    for (int h = 0; h < hold; h++) begin
      cmd_valid = 1'b1;
      cmd = {4'b0010, 2'b11, 3'($urandom)};
      addr_lo = 3'($urandom); big_end = 1'($urandom);
      @(negedge clk);
      check("R7", em, ee);
    end
    cmd_valid = 1'b0;
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    check("R8", 8'h00, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cmd_valid = 1'b1; cmd = 9'b001011011;
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 1'b0);
    rst_n = 1'b1;
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R1", 8'h00, 1'b0);

    // Directed corner cases
    issue(9'b001011110, 3'd0, 1'b0, 1);   // 7 bytes at 0
    issue(9'b001011110, 3'd1, 1'b0, 0);   // 7 bytes at 1
    issue(9'b001011110, 3'd2, 1'b0, 2);   // 7 bytes at 2 illegal
    issue(9'b001011100, 3'd3, 1'b0, 0);   // 5 bytes at 3
    issue(9'b001011011, 3'd1, 1'b0, 0);   // word at 1 illegal
    issue(9'b001011000, 3'd1, 1'b1, 0);   // byte at 1 BE -> 40
    issue(9'b001011001, 3'd0, 1'b1, 0);   // half at 0 BE -> C0
    issue(9'b001011111, 3'd0, 1'b0, 0);   // doubleword
    issue(9'b001011111, 3'd1, 1'b1, 0);   // doubleword misaligned
    issue(9'b001010001, 3'd5, 1'b1, 3);   // block form
    issue(9'b000011011, 3'd0, 1'b0, 0);   // read request ignored
    issue(9'b101000101, 3'd0, 1'b0, 0);   // data identifier ignored
    issue(9'b001001011, 3'd0, 1'b0, 0);   // attribute 1 ignored

    // R8: ack while idle does nothing
    @(negedge clk); mem_ack = 1'b1;
    @(negedge clk); mem_ack = 1'b0;
    check("R8", 8'h00, 1'b0);

    // R2: valid low ignored
    @(negedge clk); cmd = 9'b001011000; addr_lo = 3'd0; cmd_valid = 1'b0;
    @(negedge clk);
    check("R2", 8'h00, 1'b0);

    // Exhaustive sized sweep in both byte orders
    for (int be = 0; be < 2; be++)
      for (int s = 0; s < 8; s++)
        for (int a = 0; a < 8; a++)
          issue({6'b001011, 3'(s)}, 3'(a), 1'(be), 0);

    // Constrained random mix
    for (int it = 0; it < 600; it++) begin
      logic [8:0] c;
      c = {6'b001011, 3'($urandom)};
      if ($urandom_range(0, 7) == 0) c[4:3] = 2'($urandom);
      if ($urandom_range(0, 9) == 0) c[8:5] = 4'($urandom);
      issue(c, 3'($urandom), 1'($urandom), $urandom_range(0, 3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule